// File: doc/BRIEF.md
# Dual Serial Pattern Detector

This block watches a one-bit serial stream, taking one bit on every rising clock edge. It raises one of two single-cycle flags when the four most recent bits form a particular pattern. `hit_1001` marks the pattern 1,0,0,1 and `hit_1010` marks the pattern 1,0,1,0. In both cases the oldest bit is written first. Matches may overlap, so the tail of one match can serve as the start of the next.

A single state machine tracks progress through both patterns. It has seven abstract phases:

- idle
- seen 1
- seen 10
- seen 100
- seen 101
- matched 1001
- matched 1010

On a mismatching bit, the machine moves to the longest prefix of either pattern that is still valid. A parameter selects how the phases are stored in the state register: plain binary or Gray code. Both builds can then be synthesized and their netlists compared, and they must behave identically at the ports.

Top module: `dual_pattern_fsm`

## Requirements
- R1: While `rst` is high at a rising edge, the machine returns to idle with no partial match. Both flags are low after that edge, and bits received before reset never count toward a later match.
- R2: `hit_1001` is high during the clock cycle that follows the edge sampling the final bit of 1,0,0,1. All four bits must have been received since reset.
- R3: `hit_1010` is high during the clock cycle that follows the edge sampling the final bit of 1,0,1,0. All four bits must have been received since reset.
- R4: Matches of 1001 overlap. The stream 1,0,0,1,0,0,1 gives two `hit_1001` pulses, on the 4th and 7th bits.
- R5: Matches of 1010 overlap. The stream 1,0,1,0,1,0 gives two `hit_1010` pulses, on the 4th and 6th bits.
- R6: Each flag is a one-cycle pulse: a flag is never high on two consecutive cycles.
- R7: `hit_1001` and `hit_1010` are never high in the same cycle.
- R8: With `ENCODING` set to GRAY, the state code is the Gray code of the phase index. A step between phases whose indices differ by one changes exactly one state bit. The ports produce the same flag sequence as the BINARY build for every input stream.
- R9: A run of all ones or all zeros never raises either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; `serial_in` is sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| serial_in | input | 1 | Serial data bit |
| hit_1001 | output | 1 | One-cycle pulse when the last four bits were 1,0,0,1 |
| hit_1010 | output | 1 | One-cycle pulse when the last four bits were 1,0,1,0 |

## Verification
The following are checked by assertions on every cycle:

- the return to idle under reset
- the rise of each flag after the last pattern bit
- the overlap transitions out of the two match phases
- the single-cycle width of each flag
- the mutual exclusion of the two flags
- the one-bit steps of the Gray register

Some properties can only be shown by the bench scenarios. These are that the flags follow the true four-bit history for whole streams, that a reset in mid-stream discards a partial match, and that the BINARY and GRAY builds agree. The bench shows them by running both builds side by side against a history model, using directed and biased random streams.

// File: rtl/patdet_pkg.sv
package patdet_pkg;

   typedef enum logic [1:0] {ENC_BINARY, ENC_GRAY} enc_e;

   localparam int NUM_PHASES = 7;
   localparam int PHASE_W    = $clog2(NUM_PHASES);

   // Index order puts common forward steps on adjacent Gray codes
   typedef enum logic [PHASE_W-1:0] {
      PH_IDLE  = 3'd0,
      PH_1     = 3'd1,
      PH_10    = 3'd2,
      PH_100   = 3'd3,
      PH_HIT_A = 3'd4,
      PH_101   = 3'd5,
      PH_HIT_B = 3'd6
   } phase_e;

   function automatic logic [PHASE_W-1:0] to_gray(input logic [PHASE_W-1:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [PHASE_W-1:0] from_gray(input logic [PHASE_W-1:0] g);
      logic [PHASE_W-1:0] b;
      b[PHASE_W-1] = g[PHASE_W-1];
      for (int i = PHASE_W-2; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

endpackage

// File: rtl/patdet_next.sv
module patdet_next
   import patdet_pkg::*;
(
   input  phase_e cur,
   input  logic   bit_in,
   output phase_e nxt
);

   always_comb begin
      nxt = PH_IDLE;
      unique case (cur)
         PH_IDLE:  nxt = bit_in ? PH_1     : PH_IDLE;
         PH_1:     nxt = bit_in ? PH_1     : PH_10;
         PH_10:    nxt = bit_in ? PH_101   : PH_100;
         PH_100:   nxt = bit_in ? PH_HIT_A : PH_IDLE;
         PH_101:   nxt = bit_in ? PH_1     : PH_HIT_B;
         PH_HIT_A: nxt = bit_in ? PH_1     : PH_10;
         PH_HIT_B: nxt = bit_in ? PH_101   : PH_100;
         default:  nxt = PH_IDLE;
      endcase
   end

endmodule

// File: rtl/patdet_state_reg.sv
module patdet_state_reg
   import patdet_pkg::*;
#(
   parameter enc_e ENCODING = ENC_BINARY
)(
   input  logic   clk,
   input  logic   rst,
   input  phase_e nxt,
   output phase_e cur
);

   localparam int CODE_W = PHASE_W;

   logic [CODE_W-1:0] code_d;
   logic [CODE_W-1:0] code_q;
   logic [CODE_W-1:0] idx_q;

   if (CODE_W < $clog2(NUM_PHASES)) begin : g_width_check
      $error("state code too narrow for %0d phases", NUM_PHASES);
   end

   if (ENCODING == ENC_GRAY) begin : g_gray
      assign code_d = to_gray(nxt);
      assign idx_q  = from_gray(code_q);
   end else if (ENCODING == ENC_BINARY) begin : g_binary
      assign code_d = nxt;
      assign idx_q  = code_q;
   end else begin : g_bad_enc
      $error("unsupported state encoding");
      assign code_d = '0;
      assign idx_q  = '0;
   end

   always_ff @(posedge clk) begin
      if (rst) code_q <= (ENCODING == ENC_GRAY) ? to_gray(PH_IDLE) : PH_IDLE;
      else     code_q <= code_d;
   end

   assign cur = phase_e'(idx_q);

   if (ENCODING == ENC_GRAY) begin : g_gray_chk
      p_gray_step_r8: assert property (@(posedge clk) disable iff (rst)
         ((int'(idx_q) == int'($past(idx_q)) + 1) || (int'(idx_q) + 1 == int'($past(idx_q))))
         |-> ($countones(code_q ^ $past(code_q)) == 1));
   end

endmodule

// File: rtl/dual_pattern_fsm.sv
module dual_pattern_fsm
   import patdet_pkg::*;
#(
   parameter enc_e ENCODING = ENC_BINARY
)(
   input  logic clk,
   input  logic rst,
   input  logic serial_in,
   output logic hit_1001,
   output logic hit_1010
);

   phase_e cur;
   phase_e nxt;

   patdet_next u_next (
      .cur    (cur),
      .bit_in (serial_in),
      .nxt    (nxt)
   );

   patdet_state_reg #(.ENCODING(ENCODING)) u_state (
      .clk (clk),
      .rst (rst),
      .nxt (nxt),
      .cur (cur)
   );

   // Flags registered beside the state, so outputs come straight from flops
   always_ff @(posedge clk) begin
      if (rst) begin
         hit_1001 <= 1'b0;
         hit_1010 <= 1'b0;
      end else begin
         hit_1001 <= (nxt == PH_HIT_A);
         hit_1010 <= (nxt == PH_HIT_B);
      end
   end

   p_reset_idle_r1: assert property (@(posedge clk)
      rst |=> (cur == PH_IDLE && !hit_1001 && !hit_1010));

   p_flag_a_r2: assert property (@(posedge clk) disable iff (rst)
      (cur == PH_100 && serial_in) |=> hit_1001);

   p_flag_a_state_r2: assert property (@(posedge clk) disable iff (rst)
      hit_1001 == (cur == PH_HIT_A));

   p_flag_b_r3: assert property (@(posedge clk) disable iff (rst)
      (cur == PH_101 && !serial_in) |=> hit_1010);

   p_overlap_a_r4: assert property (@(posedge clk) disable iff (rst)
      (cur == PH_HIT_A && !serial_in) |=> (cur == PH_10));

   p_overlap_b_r5: assert property (@(posedge clk) disable iff (rst)
      (cur == PH_HIT_B && serial_in) |=> (cur == PH_101));

   p_pulse_a_r6: assert property (@(posedge clk) disable iff (rst)
      hit_1001 |=> !hit_1001);

   p_pulse_b_r6: assert property (@(posedge clk) disable iff (rst)
      hit_1010 |=> !hit_1010);

   p_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
      !(hit_1001 && hit_1010));

endmodule

// File: tb/test_dual_pattern_fsm.sv
module test_dual_pattern_fsm;
   import patdet_pkg::*;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst = 1'b1;
   logic serial_in = 1'b0;
   logic b_a, b_b, g_a, g_b;

   dual_pattern_fsm #(.ENCODING(ENC_BINARY)) i_dual_pattern_fsm (
      .clk(clk), .rst(rst), .serial_in(serial_in), .hit_1001(b_a), .hit_1010(b_b));

   dual_pattern_fsm #(.ENCODING(ENC_GRAY)) i_dual_pattern_fsm_gray (
      .clk(clk), .rst(rst), .serial_in(serial_in), .hit_1001(g_a), .hit_1010(g_b));

   int checks = 0;
   int fails  = 0;
   logic [3:0] hist = 4'b0;
   int seen = 0;
   logic prev_a = 1'b0, prev_b = 1'b0;
   bit done = 1'b0;

   task automatic chk(input string req, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
      end
   endtask

   function automatic logic exp_flag(input logic [3:0] h, input int n, input logic [3:0] pat);
      return (n >= 4) && (h == pat);
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      serial_in = 1'b0;
      @(posedge clk);
      @(posedge clk);
      #1;
      chk("R1", b_a, 1'b0, "hit_1001 under reset");
      chk("R1", b_b, 1'b0, "hit_1010 under reset");
      chk("R1", g_a, 1'b0, "gray hit_1001 under reset");
      chk("R1", g_b, 1'b0, "gray hit_1010 under reset");
      hist = 4'b0;
      seen = 0;
      prev_a = 1'b0;
      prev_b = 1'b0;
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic send(input logic b, input string req);
      logic ea, eb;
      @(negedge clk);
      serial_in = b;
      @(posedge clk);
      #1;
      hist = {hist[2:0], b};
      if (seen < 4) seen++;
      ea = exp_flag(hist, seen, 4'b1001);
      eb = exp_flag(hist, seen, 4'b1010);
      chk(req, b_a, ea, "hit_1001");
      chk(req, b_b, eb, "hit_1010");
      chk("R8", g_a, ea, "gray hit_1001");
      chk("R8", g_b, eb, "gray hit_1010");
      chk("R7", b_a & b_b, 1'b0, "both flags high");
      if (prev_a) chk("R6", b_a, 1'b0, "hit_1001 second cycle");
      if (prev_b) chk("R6", b_b, 1'b0, "hit_1010 second cycle");
      prev_a = b_a;
      prev_b = b_b;
   endtask

   task automatic send_nib(input logic [3:0] n, input string req);
      for (int i = 3; i >= 0; i--) send(n[i], req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      do_reset();

      // R2 single match, then R4 overlapping second match
      send_nib(4'b1001, "R2");
      send(1'b0, "R4"); send(1'b0, "R4"); send(1'b1, "R4");
      chk("R4", b_a, 1'b1, "second overlapped hit_1001");

      do_reset();
      // R3 single match, then R5 overlapping matches
      send_nib(4'b1010, "R3");
      send(1'b1, "R5"); send(1'b0, "R5");
      chk("R5", b_b, 1'b1, "second overlapped hit_1010");
      send(1'b1, "R5"); send(1'b0, "R5");

      // R9 constant runs
      for (int i = 0; i < 8; i++) send(1'b1, "R9");
      for (int i = 0; i < 8; i++) send(1'b0, "R9");

      // R1 partial match discarded by reset
      send(1'b1, "R1"); send(1'b0, "R1"); send(1'b0, "R1");
      do_reset();
      send(1'b1, "R1");
      chk("R1", b_a, 1'b0, "no hit after reset split 100|1");

      // biased random streams
      for (int k = 0; k < 1500; k++) begin
         int r;
         r = int'($urandom % 6);
         if (r == 0)      send_nib(4'b1001, "R2");
         else if (r == 1) send_nib(4'b1010, "R3");
         else if (r == 2) send_nib(4'b1011, "R3");
         else             send(1'($urandom % 2), "R2");
         if ((k % 500) == 499) do_reset();
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule